// File: doc/BRIEF.md
# SECDED-protected simple dual-port memory

This block is a word-organised memory with one write port and one independent read port. Each word carries 64 data bits. On the write side, an encoder adds seven Hamming check bits and one overall parity bit, and the block stores the resulting 72-bit codeword. On the read side, the stored codeword goes through a decoder. The decoder recomputes the syndrome, repairs any single flipped bit and flags any double flip as uncorrectable. The repaired data, a single-error flag, a double-error flag and the 8-bit syndrome then leave the block together.

The encoder and the decoder are separate modules that hold no state. They can also be placed around an external 72-bit memory. A 72-bit injection mask on the write port is XORed into the codeword before it is stored, so a test can plant faults at any bit. Reading and writing the same address in the same cycle is not supported, and the read result in that case is undefined.

Top module: `ecc_sdp_mem`

## Requirements
- R1: The stored 72-bit codeword uses position 0 for the overall parity bit and the positions 1, 2, 4, 8, 16, 32 and 64 for Hamming check bits. Data bits fill the remaining positions 3, 5, 6, 7, 9 and upward in ascending order, with data bit 0 at position 3. An encoded word has an all-zero syndrome and even overall parity.
- R2: A read of a word written with an all-zero injection mask returns the written data, with err_single=0, err_double=0 and err_syndrome=0.
- R3: If exactly one of the 72 stored bits is flipped, at any position 0 to 71, the read returns the original data with err_single=1 and err_double=0.
- R4: err_syndrome[6:0] is the XOR of the positions of the flipped bits, and err_syndrome[7] is 1 when the stored word has odd overall parity. For a single flip at position j, err_syndrome equals {1'b1, j}.
- R5: If exactly two distinct stored bits i and j are flipped, the read gives err_double=1 and err_single=0, with err_syndrome = {1'b0, i XOR j}. The data is not corrected in this case.
- R6: When rd_en is sampled high at a clock edge, rd_valid is high after the second following edge. rd_data and the flags are valid in that same cycle. rd_valid is high for exactly one cycle per read.
- R7: wr_inject is XORed into the codeword only when it is written. Writing the same address again with a zero mask removes the fault.
- R8: After a synchronous active-low reset, rd_valid, rd_data, err_single, err_double and err_syndrome are all zero.
- R9: While rd_valid is low, rd_data and the error outputs keep their last values.
- R10: A write to one address and a read from a different address in the same cycle both take effect. The read returns the word stored before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (5) | Write address |
| wr_data | input | 64 | Data to store |
| wr_inject | input | 72 | Bit-flip mask XORed into the stored codeword |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (5) | Read address |
| rd_valid | output | 1 | Read result valid, two cycles after rd_en |
| rd_data | output | 64 | Corrected read data |
| err_single | output | 1 | A single-bit error was corrected |
| err_double | output | 1 | An uncorrectable double-bit error was found |
| err_syndrome | output | 8 | {overall parity, 7-bit Hamming syndrome} |

## Verification
Faults in the stored codeword cannot occur in normal operation, so the bench plants them with the write-side injection mask. It sweeps every one of the 72 single-bit positions and every one of the 2556 distinct bit pairs. For each fault, the bench computes the expected syndrome from the positions it flipped and checks the flags and the data at the exact cycle the result is due. It covers the two hardest-to-reach cases explicitly: a flip of the overall parity bit alone, and a double flip that includes the parity bit. A rewrite with a zero mask, and a write and a read at different addresses in the same cycle, round out the write-path checks.

// File: rtl/ecc_pkg.sv
// ecc_pkg: widths and pure functions of the extended Hamming code.
// Assumes DATA_W is a power of two, so that $clog2(DATA_W)+1 check bits cover it.
package ecc_pkg;
    localparam int DATA_W = 64;
    localparam int HAM_W  = $clog2(DATA_W) + 1;
    localparam int CODE_W = DATA_W + HAM_W + 1;
    localparam int SYN_W  = HAM_W + 1;

    // True when p is a power of two (a check-bit position).
    function automatic bit is_pow2(input int p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

    // Place the data bits and compute the check bits and the overall parity.
    function automatic logic [CODE_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] cw;
        logic              par;
        int                k;
        cw = '0;
        k  = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < HAM_W; b++) begin
            par = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (p[b] && !is_pow2(p)) par ^= cw[p];
            end
            cw[1 << b] = par;
        end
        cw[0] = ^cw[CODE_W-1:1];
        return cw;
    endfunction

    // XOR of the positions of all set bits at positions 1 and above.
    function automatic logic [HAM_W-1:0] ecc_syndrome(input logic [CODE_W-1:0] cw);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (cw[p]) s ^= HAM_W'(p);
        end
        return s;
    endfunction

    // Collect the data bits back out of their codeword positions.
    function automatic logic [DATA_W-1:0] ecc_extract(input logic [CODE_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int                k;
        d = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
// ecc_encoder: combinational SECDED encoder, 64 data bits into a 72-bit codeword.
// It holds no state and can also front an external memory.
module ecc_encoder
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out
);
    // Build the codeword.
    always_comb code_out = ecc_encode(data_in);

    // Check that a fresh codeword decodes clean.
    always_comb begin
        if (!$isunknown(data_in)) begin
            AST_ENC_CLEAN: assert (ecc_syndrome(code_out) == '0 && (^code_out) == 1'b0); // R1
        end
    end
endmodule

// File: rtl/ecc_decoder.sv
// ecc_decoder: combinational SECDED decoder. It corrects a single flip,
// including a flip of the parity bit, and flags double or out-of-range faults.
// It holds no state.
module ecc_decoder
    import ecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              single_err,
    output logic              double_err,
    output logic [SYN_W-1:0]  syndrome
);
    logic [HAM_W-1:0]  syn;
    logic              par_bad;
    logic              in_range;
    logic [CODE_W-1:0] flip;

    // Syndrome and overall parity of the received word.
    always_comb begin
        syn      = ecc_syndrome(code_in);
        par_bad  = ^code_in;
        in_range = int'(syn) < CODE_W;
    end

    // One-hot repair mask, used only for a correctable error.
    always_comb begin
        for (int p = 0; p < CODE_W; p++) begin
            flip[p] = par_bad && in_range && (int'(syn) == p);
        end
    end

    // Classify the error and produce the repaired data.
    always_comb begin
        single_err = par_bad && in_range;
        double_err = (!par_bad && syn != '0) || (par_bad && !in_range);
        data_out   = ecc_extract(code_in ^ flip);
        syndrome   = {par_bad, syn};
    end

    // At most one bit is repaired.
    always_comb begin
        if (!$isunknown(code_in)) begin
            AST_ONE_FLIP: assert ($onehot0(flip)); // R3
        end
    end
endmodule

// File: rtl/ecc_sdp_array.sv
// ecc_sdp_array: codeword storage with one write port and one registered read port.
// It assumes no read of an address in the cycle that address is written.
module ecc_sdp_array
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [CODE_W-1:0] wr_inject,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CODE_W-1:0] rd_code,
    output logic              rd_vld
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CODE_W-1:0] mem [DEPTH];

    // Store the codeword with the fault mask applied.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_code ^ wr_inject;
    end

    // Register the read word.
    always_ff @(posedge clk) begin
        if (rd_en) rd_code <= mem[rd_addr];
    end

    // Read-valid flag for the array stage.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_vld <= 1'b0;
        else        rd_vld <= rd_en;
    end

    AST_ARR_PIPE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_vld); // R6
endmodule

// File: rtl/ecc_sdp_mem.sv
// ecc_sdp_mem: SECDED-protected simple dual-port memory. It encodes on write and
// decodes in a registered stage after the array, giving two cycles of read latency.
// It assumes the read and write addresses differ whenever both strobes are high.
module ecc_sdp_mem
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CODE_W-1:0] wr_inject,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_single,
    output logic              err_double,
    output logic [SYN_W-1:0]  err_syndrome
);
    logic [CODE_W-1:0] enc_code;
    logic [CODE_W-1:0] arr_code;
    logic              arr_vld;
    logic [DATA_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_double;
    logic [SYN_W-1:0]  dec_syn;

    ecc_encoder u_enc (
        .data_in  (wr_data),
        .code_out (enc_code)
    );

    ecc_sdp_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_code   (enc_code),
        .wr_inject (wr_inject),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_code   (arr_code),
        .rd_vld    (arr_vld)
    );

    ecc_decoder u_dec (
        .code_in    (arr_code),
        .data_out   (dec_data),
        .single_err (dec_single),
        .double_err (dec_double),
        .syndrome   (dec_syn)
    );

    // Output register for the decoded result, loaded only when a read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            err_single   <= 1'b0;
            err_double   <= 1'b0;
            err_syndrome <= '0;
        end else begin
            rd_valid <= arr_vld;
            if (arr_vld) begin
                rd_data      <= dec_data;
                err_single   <= dec_single;
                err_double   <= dec_double;
                err_syndrome <= dec_syn;
            end
        end
    end

    AST_DEC_PIPE: assert property (@(posedge clk) disable iff (!rst_n) arr_vld |=> rd_valid); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(err_single && err_double)); // R5
    AST_SINGLE_PARITY: assert property (@(posedge clk) disable iff (!rst_n) err_single |-> err_syndrome[HAM_W]); // R4
    AST_DOUBLE_SYN: assert property (@(posedge clk) disable iff (!rst_n) err_double |-> err_syndrome[HAM_W-1:0] != '0); // R5
    AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && err_syndrome == '0) |-> (!err_single && !err_double)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid |-> ($stable(rd_data) && $stable(err_syndrome))); // R9
endmodule

// File: tb/ecc_sdp_mem_test.sv
module ecc_sdp_mem_test;
    localparam int AW = 5;
    localparam int DW = 64;
    localparam int CW = 72;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [CW-1:0] wr_inject;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          err_single;
    logic          err_double;
    logic [7:0]    err_syndrome;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    ecc_sdp_mem #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_inject(wr_inject), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_single(err_single),
        .err_double(err_double), .err_syndrome(err_syndrome)
    );

    function automatic logic [DW-1:0] pat(input int n);
        logic [31:0] a;
        logic [31:0] b;
        a = 32'(n) * 32'h9E3779B1;
        b = ~(32'(n) * 32'h85EBCA6B);
        return {a, b};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write a word with a mask, then read it back; the result is sampled when due.
    task automatic wr_rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [CW-1:0] m,
                         output bit mid_v, output bit v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_inject = m;
        @(negedge clk);
        wr_en = 1'b0; wr_inject = '0;
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        mid_v = rd_valid;
        @(negedge clk);
        v = rd_valid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit mv;
        bit v;
        logic [DW-1:0] d;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; rd_addr = '0; wr_data = '0; wr_inject = '0;
        repeat (4) @(negedge clk);
        // R8: outputs are zero after reset
        check(rd_valid == 1'b0 && rd_data == '0 && !err_single && !err_double && err_syndrome == 8'h00,
              "R8 reset state", {rd_valid, err_single, err_double, err_syndrome, rd_data}, '0);
        rst_n = 1'b1;

        // R2 and R6: clean words at every address
        for (int a = 0; a < (1 << AW); a++) begin
            d = pat(a + 100);
            wr_rd(AW'(a), d, '0, mv, v);
            check(!mv && v, "R6 valid timing", {mv, v}, 2'b01);
            check(rd_data == d && !err_single && !err_double && err_syndrome == 8'h00,
                  "R2 clean read", {err_single, err_double, err_syndrome, rd_data}, {2'b00, 8'h00, d});
        end

        // R9: outputs hold while idle
        d = rd_data;
        @(negedge clk);
        @(negedge clk);
        check(!rd_valid && rd_data == d && err_syndrome == 8'h00, "R9 hold when idle",
              {rd_valid, rd_data}, {1'b0, d});

        // R1 R3 R4: every single-bit position
        for (int j = 0; j < CW; j++) begin
            d = pat(j * 7 + 3);
            wr_rd(AW'(j), d, CW'(1) << j, mv, v);
            check(v && rd_data == d && err_single && !err_double, "R3 single corrected",
                  {v, err_single, err_double, rd_data}, {3'b110, d});
            check(err_syndrome == {1'b1, 7'(j)}, "R1 R4 single syndrome",
                  128'(err_syndrome), 128'({1'b1, 7'(j)}));
        end

        // R5: every distinct double-bit pair
        for (int i = 0; i < CW; i++) begin
            for (int j = i + 1; j < CW; j++) begin
                d = pat(i * 131 + j);
                wr_rd(AW'(i + j), d, (CW'(1) << i) | (CW'(1) << j), mv, v);
                check(v && err_double && !err_single && err_syndrome == {1'b0, 7'(i ^ j)},
                      "R5 double detect", {v, err_single, err_double, err_syndrome},
                      {3'b101, 1'b0, 7'(i ^ j)});
            end
        end

        // R7: a clean rewrite removes the planted fault
        wr_rd(AW'(5), pat(9), CW'(1) << 40, mv, v);
        check(err_single, "R7 fault planted", 128'(err_single), 128'(1));
        wr_rd(AW'(5), pat(10), '0, mv, v);
        check(rd_data == pat(10) && !err_single && !err_double && err_syndrome == 8'h00,
              "R7 rewrite clears", {err_single, err_double, rd_data}, {2'b00, pat(10)});

        // R10: write and read at different addresses in the same cycle
        wr_rd(AW'(2), pat(222), '0, mv, v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(1); wr_data = pat(111); wr_inject = '0;
        rd_en = 1'b1; rd_addr = AW'(2);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        check(rd_valid && rd_data == pat(222) && !err_single && !err_double, "R10 concurrent read",
              {rd_valid, rd_data}, {1'b1, pat(222)});
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(1);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check(rd_valid && rd_data == pat(111) && !err_single && !err_double, "R10 concurrent write",
              {rd_valid, rd_data}, {1'b1, pat(111)});

        // R6: exactly one valid cycle per read
        @(negedge clk);
        check(!rd_valid, "R6 single valid pulse", 128'(rd_valid), 128'(0));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule